// File: doc/BRIEF.md
# Four-Way Age-Counter Replacement Tracker

This block keeps the replacement order for a single four-way set of a set-associative cache. Each way has a valid bit and a small age counter. Age 0 marks the most recently touched way. In a full set, the highest age marks the way that has gone longest without a reference. Each cycle the surrounding cache controller presents at most one event: a hit on a named way, or a miss fill. The tracker updates the ages so that the counters of valid ways always stay pairwise distinct.

A combinational output names the way that the next fill will write. While the set still has an empty way, this is the lowest-numbered invalid way. Once all ways are valid, it is the way holding the maximum age. A companion flag reports whether the set is full. Tag comparison, data storage, multiple sets and randomised victim choice belong to other blocks.

Top module: `lru_age_tracker`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), all valid bits read 0, all ages read 0, victim_way reads 0 and set_full reads 0.
- R2: While at least one way is invalid, victim_way names the lowest-numbered invalid way.
- R3: A fill (evt_kind = 2'b10) into a set that is not full makes the victim way valid with age 0. It adds one to every other valid way's age and leaves the age of every invalid way at 0.
- R4: set_full is 1 exactly when all four valid bits are 1.
- R5: While the set is full, victim_way names the way whose age is 3.
- R6: A fill into a full set gives the victim way age 0, keeps it valid, and adds one to the age of each of the other three ways.
- R7: A hit (evt_kind = 2'b01) on a valid way evt_way sets that way's age to 0. It adds one to each valid way whose age was below the hit way's old age, and leaves every other age and every valid bit unchanged.
- R8: A hit on an invalid way changes no valid bit and no age.
- R9: An idle code (evt_kind = 2'b00 or 2'b11) changes no valid bit and no age.
- R10: The ages of valid ways are pairwise distinct at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evt_kind | input | 2 | 00 idle, 01 hit, 10 miss fill, 11 idle |
| evt_way | input | 2 | Way index that a hit refers to |
| victim_way | output | 2 | Way that the next fill will use |
| set_full | output | 1 | All ways valid |
| way_valid | output | 4 | Valid bit of way i at bit i |
| way_ages | output | 8 | Age of way i at bits [2i+1:2i] |

## Verification
The bench fills the set from empty one way at a time and checks that the victim moves to the lowest invalid way. A tracker that scanned from the top, or that aged invalid ways, would show the wrong way or non-zero ages there. It hits the oldest, the youngest and a middle way, so that a design comparing with "less or equal", or ageing every way, breaks the distinct-age rule. It also runs back-to-back fills into a full set, where a wrong victim choice would evict a recently used way. Hits on invalid ways and idle codes are sent between these events, and the state must not move.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;
   typedef enum logic [1:0] {
      EVT_IDLE  = 2'b00,
      EVT_HIT   = 2'b01,
      EVT_FILL  = 2'b10,
      EVT_SPARE = 2'b11
   } evt_kind_e;
endpackage

// File: rtl/lru_victim_sel.sv
module lru_victim_sel #(
   parameter int WAYS  = 4,
   parameter int WAY_W = $clog2(WAYS),
   parameter int AGE_W = $clog2(WAYS)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [WAYS-1:0]         valid_vec,
   input  logic [WAYS*AGE_W-1:0]   age_vec,
   output logic [WAY_W-1:0]        victim,
   output logic                    full
);
   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

   logic [WAY_W-1:0] first_free;
   logic [WAY_W-1:0] oldest;

   always_comb begin
      first_free = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (!valid_vec[i]) first_free = WAY_W'(i);
      end
   end

   always_comb begin
      oldest = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (age_vec[i*AGE_W +: AGE_W] == AGE_MAX) oldest = WAY_W'(i);
      end
   end

   assign full   = &valid_vec;
   assign victim = full ? oldest : first_free;

   // R2: a set with room never picks an occupied way
   assert_victim_empty_R2: assert property (@(posedge clk) disable iff (rst)
      !full |-> !valid_vec[victim]);

   // R5: a full set evicts the oldest way
   assert_full_victim_old_R5: assert property (@(posedge clk) disable iff (rst)
      full |-> (age_vec[victim*AGE_W +: AGE_W] == AGE_MAX));
endmodule

// File: rtl/lru_age_cell.sv
module lru_age_cell #(
   parameter int AGE_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             do_hit,
   input  logic             do_fill,
   input  logic             is_target,
   input  logic [AGE_W-1:0] ref_age,
   output logic             valid_q,
   output logic [AGE_W-1:0] age_q
);
   localparam logic [AGE_W-1:0] AGE_TOP = '1;

   logic             valid_d;
   logic [AGE_W-1:0] age_d;
   logic             bump;

   always_comb begin
      valid_d = valid_q;
      age_d   = age_q;
      bump    = 1'b0;
      if (do_fill) begin
         if (is_target) begin
            valid_d = 1'b1;
            age_d   = '0;
         end else begin
            bump = valid_q;
         end
      end else if (do_hit) begin
         if (is_target) age_d = '0;
         else           bump  = valid_q && (age_q < ref_age);
      end
      if (bump && age_q != AGE_TOP) age_d = age_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         age_q   <= '0;
      end else begin
         valid_q <= valid_d;
         age_q   <= age_d;
      end
   end

   // R3: an empty way never ages
   assert_invalid_age_zero_R3: assert property (@(posedge clk) disable iff (rst)
      !valid_q |-> (age_q == '0));

   // R7: a targeted hit clears the age
   assert_hit_clears_R7: assert property (@(posedge clk) disable iff (rst)
      (do_hit && is_target) |=> (age_q == '0));
endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker #(
   parameter int WAYS  = 4,
   parameter int WAY_W = $clog2(WAYS),
   parameter int AGE_W = $clog2(WAYS)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [1:0]            evt_kind,
   input  logic [WAY_W-1:0]      evt_way,
   output logic [WAY_W-1:0]      victim_way,
   output logic                  set_full,
   output logic [WAYS-1:0]       way_valid,
   output logic [WAYS*AGE_W-1:0] way_ages
);
   import lru_age_pkg::*;

   initial begin
      assert (WAYS >= 2 && (WAYS & (WAYS - 1)) == 0)
         else $error("WAYS must be a power of two of at least 2");
      assert (AGE_W == $clog2(WAYS) && WAY_W == $clog2(WAYS))
         else $error("AGE_W and WAY_W must equal log2(WAYS)");
   end

   logic             do_hit;
   logic             do_fill;
   logic [WAY_W-1:0] target;
   logic [AGE_W-1:0] ref_age;

   assign ref_age = way_ages[evt_way*AGE_W +: AGE_W];
   assign do_hit  = (evt_kind == EVT_HIT) && way_valid[evt_way];
   assign do_fill = (evt_kind == EVT_FILL);
   assign target  = do_fill ? victim_way : evt_way;

   lru_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)) sel_i (
      .clk       (clk),
      .rst       (rst),
      .valid_vec (way_valid),
      .age_vec   (way_ages),
      .victim    (victim_way),
      .full      (set_full)
   );

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      lru_age_cell #(.AGE_W(AGE_W)) cell_i (
         .clk       (clk),
         .rst       (rst),
         .do_hit    (do_hit),
         .do_fill   (do_fill),
         .is_target (target == WAY_W'(w)),
         .ref_age   (ref_age),
         .valid_q   (way_valid[w]),
         .age_q     (way_ages[w*AGE_W +: AGE_W])
      );
   end

   logic age_clash;
   always_comb begin
      age_clash = 1'b0;
      for (int a = 0; a < WAYS; a++) begin
         for (int b = a + 1; b < WAYS; b++) begin
            if (way_valid[a] && way_valid[b] &&
                way_ages[a*AGE_W +: AGE_W] == way_ages[b*AGE_W +: AGE_W])
               age_clash = 1'b1;
         end
      end
   end

   // R10: occupied ways never share an age
   assert_ages_distinct_R10: assert property (@(posedge clk) disable iff (rst)
      !age_clash);

   // R8: a hit on an empty way is illegal and leaves state alone
   assert_hit_invalid_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (evt_kind == EVT_HIT && !way_valid[evt_way]) |=> ($stable(way_valid) && $stable(way_ages)));

   // R9: idle codes leave state alone
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (evt_kind == EVT_IDLE || evt_kind == EVT_SPARE) |=> ($stable(way_valid) && $stable(way_ages)));

   // R6: a fill always leaves one more or the same number of valid ways, never fewer
   assert_fill_no_loss_R6: assert property (@(posedge clk) disable iff (rst)
      do_fill |=> ($countones(way_valid) >= $countones($past(way_valid))));

   // R1: reset clears every valid bit
   assert_reset_clear_R1: assert property (@(posedge clk)
      $past(rst) |-> (way_valid == '0 && way_ages == '0));
endmodule

// File: tb/lru_age_tracker_tb_top.sv
module lru_age_tracker_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] evt_kind = 2'b00;
   logic [1:0] evt_way = 2'b00;
   logic [1:0] victim_way;
   logic       set_full;
   logic [3:0] way_valid;
   logic [7:0] way_ages;

   int n_chk = 0;
   int n_bad = 0;
   int m_age [4];
   bit m_val [4];

   always #4 clk = ~clk;

   lru_age_tracker dut_i (
      .clk(clk), .rst(rst), .evt_kind(evt_kind), .evt_way(evt_way),
      .victim_way(victim_way), .set_full(set_full),
      .way_valid(way_valid), .way_ages(way_ages)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit m_full();
      return m_val[0] && m_val[1] && m_val[2] && m_val[3];
   endfunction

   function automatic int m_victim();
      if (!m_full()) begin
         for (int i = 0; i < 4; i++) if (!m_val[i]) return i;
      end
      for (int i = 0; i < 4; i++) if (m_age[i] == 3) return i;
      return 0;
   endfunction

   task automatic chk_state(input string tag);
      for (int i = 0; i < 4; i++) begin
         chk(way_valid[i] == m_val[i], {tag, " valid"}, way_valid[i], m_val[i]);
         chk(way_ages[2*i +: 2] == m_age[i], {tag, " age"}, way_ages[2*i +: 2], m_age[i]);
      end
      for (int a = 0; a < 4; a++)
         for (int b = a + 1; b < 4; b++)
            if (way_valid[a] && way_valid[b])
               chk(way_ages[2*a +: 2] != way_ages[2*b +: 2], "R10 distinct", way_ages[2*a +: 2], -1);
   endtask

   // drive one event at a falling edge, check comb outputs, then resulting state
   task automatic step(input logic [1:0] kind, input logic [1:0] way, input string tag);
      int v, old;
      evt_kind = kind;
      evt_way  = way;
      #1;
      chk(set_full == m_full(), "R4 set_full", set_full, m_full());
      chk(victim_way == m_victim(), m_full() ? "R5 victim" : "R2 victim", victim_way, m_victim());
      v = m_victim();
      if (kind == 2'b10) begin
         for (int i = 0; i < 4; i++) if (i != v && m_val[i]) m_age[i]++;
         m_val[v] = 1'b1;
         m_age[v] = 0;
      end else if (kind == 2'b01 && m_val[way]) begin
         old = m_age[way];
         for (int i = 0; i < 4; i++) if (i != way && m_val[i] && m_age[i] < old) m_age[i]++;
         m_age[way] = 0;
      end
      @(posedge clk);
      @(negedge clk);
      evt_kind = 2'b00;
      chk_state(tag);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 4; i++) begin m_val[i] = 0; m_age[i] = 0; end
      chk(way_valid == 4'b0, "R1 valid", way_valid, 0);
      chk(way_ages == 8'b0, "R1 ages", way_ages, 0);
      chk(victim_way == 2'd0, "R1 victim", victim_way, 0);
      chk(set_full == 1'b0, "R1 full", set_full, 0);
   endtask

   task automatic t_fill_empty();
      step(2'b10, 2'd3, "R3 fill0");
      step(2'b10, 2'd0, "R3 fill1");
      step(2'b01, 2'd2, "R8 hit invalid");
      step(2'b10, 2'd1, "R3 fill2");
      // expected ages now: way0=2 way1=1 way2=0
      chk(way_ages[5:0] == 6'b00_01_10, "R3 ages after 3 fills", way_ages[5:0], 6'b00_01_10);
      chk(way_ages[7:6] == 2'd0, "R3 invalid stays 0", way_ages[7:6], 0);
      step(2'b10, 2'd0, "R3 fill3");
      chk(set_full == 1'b1, "R4 full after 4 fills", set_full, 1);
   endtask

   task automatic t_hits();
      step(2'b01, 2'd0, "R7 hit oldest");
      step(2'b01, 2'd0, "R7 hit youngest");
      step(2'b01, 2'd2, "R7 hit middle");
      step(2'b01, 2'd3, "R7 hit way3");
      step(2'b00, 2'd1, "R9 idle");
      step(2'b11, 2'd2, "R9 spare");
   endtask

   task automatic t_full_miss();
      for (int k = 0; k < 6; k++) step(2'b10, 2'd0, "R6 full fill");
      step(2'b01, 2'd1, "R7 hit after evict");
      step(2'b10, 2'd0, "R6 fill after hit");
   endtask

   task automatic t_partial_hits();
      t_reset();
      step(2'b10, 2'd0, "R3 refill0");
      step(2'b10, 2'd0, "R3 refill1");
      step(2'b01, 2'd0, "R7 hit in partial");
      step(2'b01, 2'd3, "R8 hit invalid3");
      step(2'b10, 2'd0, "R3 refill2");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_fill_empty();
      t_hits();
      t_full_miss();
      t_partial_hits();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule